// File: doc/BRIEF.md
# Left-Rotate Execution Unit

This unit performs one of two 8-bit left rotations on a single operand and produces the new flag byte. In the through-carry rotation, operand bit 7 goes to the carry and the old carry enters bit 0. In the circular rotation, bit 7 goes to both the carry and bit 0. The operand can be an internal register or a byte in memory. The caller presents one operation per `op_valid` pulse. For the paged encoding it supplies the second opcode byte. For the one-byte accumulator encoding it supplies nothing more. It also supplies the current value of the operand register, the current flag byte, a pointer address, an index base with a signed displacement, and a flag that shows whether a mode-override prefix was seen.

The unit is controlled by a five-state machine:

- **IDLE** waits for `op_valid`. A register operand moves to **REGDONE**. A memory operand moves to **READ**.
- **REGDONE** raises `done` and `reg_we` for one cycle, then returns to IDLE.
- **READ** issues a one-cycle memory read at the latched address, then moves to **LATCH**.
- In **LATCH** the memory returns the byte. The unit rotates it and registers the result and flags, then moves to **WRITE**.
- **WRITE** writes the byte back to the same address, presents the new flags and raises `done`, then returns to IDLE.

The `cycles` output gives the instruction's architectural cycle count. The surrounding core uses it for timing accounting. It is not the unit's own latency.

Top module: `rotl_exec_unit`

## Requirements
- R1: With opcode bit 4 = 1 (paged codes 10h-17h) or in the accumulator form, the result is {operand[6:0], old carry}, and the new carry is operand bit 7.
- R2: With opcode bit 4 = 0 (paged codes 00h-07h), the result is {operand[6:0], operand[7]}, and the new carry is operand bit 7.
- R3: Flag byte layout is S=bit7, Z=bit6, H=bit4, P/V=bit2, N=bit1, C=bit0. In the paged forms: S is result bit 7, Z is 1 when the result is zero, P/V is 1 when the result has an even number of ones, H and N are 0, and bits 5 and 3 pass through from `flags_in`.
- R4: In the accumulator form (`page_form`=0), the operand is register code 7. S, Z, P/V and bits 5 and 3 are unchanged. H and N are cleared. C takes old bit 7.
- R5: Opcode bits 2..0 select the operand: B=0, C=1, D=2, E=3, H=4, L=5, A=7, and 6 = memory. Opcode bits 7..5 and 3 are not decoded.
- R6: A register operation raises `done` and `reg_we` together for exactly one cycle, one cycle after acceptance. `reg_sel` equals the operand code. `mem_rd` and `mem_wr` stay low.
- R7: A memory operation drives `mem_rd` in the cycle after acceptance and samples `mem_rdata` one cycle later. In the following cycle it drives `mem_wr` with the rotated byte at the same address. `done` and the new flags appear with the write, and `reg_we` stays low.
- R8: The memory address is `ptr_addr` when `idx_sel`=0. When `idx_sel`=1 it is `idx_base` plus the sign-extended `disp`, modulo 2^ADDR_W. `idx_sel` has no effect on register operands.
- R9: `cycles` is 1 for the accumulator form, 2 for a paged register, 5 for pointer memory and 7 for indexed memory. Paged forms add 1 when `ovr_prefix`=1. The accumulator form ignores `ovr_prefix`.
- R10: `op_valid` is ignored while `busy` is high.
- R11: After reset, `busy`, `done`, `reg_we`, `mem_rd` and `mem_wr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Start an operation (sampled in IDLE) |
| page_form | input | 1 | 1 = paged opcode in `opcode`, 0 = one-byte accumulator form |
| opcode | input | 8 | Second opcode byte of the bit-operation page |
| idx_sel | input | 1 | Memory operand is index-relative |
| ovr_prefix | input | 1 | A mode-override prefix preceded the instruction |
| reg_val | input | 8 | Current value of the operand register |
| flags_in | input | 8 | Current flag byte |
| ptr_addr | input | ADDR_W | Pointer-register address |
| idx_base | input | ADDR_W | Index-register value |
| disp | input | 8 | Signed displacement |
| mem_rdata | input | 8 | Memory read data, valid the cycle after `mem_rd` |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Result and flags valid this cycle |
| reg_we | output | 1 | Register write strobe |
| reg_sel | output | 3 | Operand register code |
| result | output | 8 | Rotated value |
| flags_out | output | 8 | New flag byte |
| cycles | output | 4 | Architectural cycle count |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | 8 | Memory write data |

## Verification
The assertions check the timing and handshake rules on every cycle:

- the write comes two cycles after the read, at the same address;
- `reg_we` appears only with `done`, and `done` lasts a single cycle;
- `cycles` and `reg_sel` stay stable while an operation is in flight;
- H and N are cleared and Z/S agree with the written byte;
- the unit is quiet when idle.

The arithmetic can only be shown by the bench's scenarios: the two rotations, parity, the split between flags that are kept and flags that are computed, the address formed from a sign-extended displacement, and the cycle-count table. The bench sweeps every operand value with both carry inputs across every register code, both memory forms and every displacement.

// File: rtl/rotl_pkg.sv
package rotl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_LATCH,
        ST_WRITE,
        ST_REGDONE
    } state_e;

    typedef enum logic {
        ROT_CIRC  = 1'b0,
        ROT_CARRY = 1'b1
    } rot_e;

    localparam int FLG_S  = 7;
    localparam int FLG_Z  = 6;
    localparam int FLG_H  = 4;
    localparam int FLG_PV = 2;
    localparam int FLG_N  = 1;
    localparam int FLG_C  = 0;

    localparam logic [2:0] CODE_MEM = 3'd6;
    localparam logic [2:0] CODE_ACC = 3'd7;

    localparam logic [3:0] CYC_SHORT = 4'd1;
    localparam logic [3:0] CYC_REG   = 4'd2;
    localparam logic [3:0] CYC_PTR   = 4'd5;
    localparam logic [3:0] CYC_IDX   = 4'd7;

    typedef struct packed {
        rot_e       op;
        logic [2:0] code;
        logic       is_mem;
        logic       is_idx;
        logic       short_form;
        logic [3:0] cycles;
    } dec_t;

endpackage

// File: rtl/rotl_decode.sv
module rotl_decode
    import rotl_pkg::*;
(
    input  logic       page_form,
    input  logic [7:0] opcode,
    input  logic       idx_sel,
    input  logic       ovr_prefix,
    output dec_t       dec
);
    logic unused_opbits;
    assign unused_opbits = ^{opcode[7:5], opcode[3]};

    always_comb begin
        if (!page_form) begin
            dec.op         = ROT_CARRY;
            dec.code       = CODE_ACC;
            dec.is_mem     = 1'b0;
            dec.is_idx     = 1'b0;
            dec.short_form = 1'b1;
            dec.cycles     = CYC_SHORT;
        end else begin
            dec.op         = rot_e'(opcode[4]);
            dec.code       = opcode[2:0];
            dec.is_mem     = (opcode[2:0] == CODE_MEM);
            dec.is_idx     = (opcode[2:0] == CODE_MEM) && idx_sel;
            dec.short_form = 1'b0;
            if (opcode[2:0] != CODE_MEM)
                dec.cycles = CYC_REG + {3'b000, ovr_prefix};
            else if (idx_sel)
                dec.cycles = CYC_IDX + {3'b000, ovr_prefix};
            else
                dec.cycles = CYC_PTR + {3'b000, ovr_prefix};
        end
    end
endmodule

// File: rtl/rotl_alu.sv
module rotl_alu
    import rotl_pkg::*;
(
    input  rot_e       op,
    input  logic       short_form,
    input  logic [7:0] operand,
    input  logic [7:0] flags_in,
    output logic [7:0] result,
    output logic [7:0] flags_out
);
    logic fill_bit;

    always_comb begin
        fill_bit = (op == ROT_CARRY) ? flags_in[FLG_C] : operand[7];
        result   = {operand[6:0], fill_bit};

        flags_out         = flags_in;
        flags_out[FLG_H]  = 1'b0;
        flags_out[FLG_N]  = 1'b0;
        flags_out[FLG_C]  = operand[7];
        if (!short_form) begin
            flags_out[FLG_S]  = result[7];
            flags_out[FLG_Z]  = (result == 8'h00);
            flags_out[FLG_PV] = ~^result;
        end
    end
endmodule

// File: rtl/rotl_exec_unit.sv
module rotl_exec_unit
    import rotl_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic              page_form,
    input  logic [7:0]        opcode,
    input  logic              idx_sel,
    input  logic              ovr_prefix,
    input  logic [7:0]        reg_val,
    input  logic [7:0]        flags_in,
    input  logic [ADDR_W-1:0] ptr_addr,
    input  logic [ADDR_W-1:0] idx_base,
    input  logic [7:0]        disp,
    input  logic [7:0]        mem_rdata,
    output logic              busy,
    output logic              done,
    output logic              reg_we,
    output logic [2:0]        reg_sel,
    output logic [7:0]        result,
    output logic [7:0]        flags_out,
    output logic [3:0]        cycles,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata
);
    localparam int EXT_W = ADDR_W - 8;

    state_e            state_q, state_d;
    dec_t              dec;
    rot_e              op_q;
    logic [2:0]        code_q;
    logic [7:0]        flg_save_q;
    logic [ADDR_W-1:0] addr_q;
    logic [7:0]        result_q;
    logic [7:0]        flags_q;
    logic [3:0]        cycles_q;

    rot_e              alu_op;
    logic              alu_short;
    logic [7:0]        alu_operand;
    logic [7:0]        alu_flags_in;
    logic [7:0]        alu_result;
    logic [7:0]        alu_flags;
    logic [ADDR_W-1:0] idx_addr;

    rotl_decode u_dec (
        .page_form  (page_form),
        .opcode     (opcode),
        .idx_sel    (idx_sel),
        .ovr_prefix (ovr_prefix),
        .dec        (dec)
    );

    // one shared rotator: register operand in IDLE, memory byte in LATCH
    always_comb begin
        if (state_q == ST_LATCH) begin
            alu_op       = op_q;
            alu_short    = 1'b0;
            alu_operand  = mem_rdata;
            alu_flags_in = flg_save_q;
        end else begin
            alu_op       = dec.op;
            alu_short    = dec.short_form;
            alu_operand  = reg_val;
            alu_flags_in = flags_in;
        end
    end

    rotl_alu u_alu (
        .op         (alu_op),
        .short_form (alu_short),
        .operand    (alu_operand),
        .flags_in   (alu_flags_in),
        .result     (alu_result),
        .flags_out  (alu_flags)
    );

    assign idx_addr = idx_base + {{EXT_W{disp[7]}}, disp};

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (op_valid) state_d = dec.is_mem ? ST_READ : ST_REGDONE;
            ST_READ:    state_d = ST_LATCH;
            ST_LATCH:   state_d = ST_WRITE;
            ST_WRITE:   state_d = ST_IDLE;
            ST_REGDONE: state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // state register and datapath captures
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            op_q       <= ROT_CIRC;
            code_q     <= 3'd0;
            flg_save_q <= 8'h00;
            addr_q     <= '0;
            result_q   <= 8'h00;
            flags_q    <= 8'h00;
            cycles_q   <= 4'd0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && op_valid) begin
                op_q       <= dec.op;
                code_q     <= dec.code;
                flg_save_q <= flags_in;
                cycles_q   <= dec.cycles;
                addr_q     <= dec.is_idx ? idx_addr : ptr_addr;
                if (!dec.is_mem) begin
                    result_q <= alu_result;
                    flags_q  <= alu_flags;
                end
            end
            if (state_q == ST_LATCH) begin
                result_q <= alu_result;
                flags_q  <= alu_flags;
            end
        end
    end

    // outputs
    always_comb begin
        busy      = (state_q != ST_IDLE);
        done      = (state_q == ST_WRITE) || (state_q == ST_REGDONE);
        reg_we    = (state_q == ST_REGDONE);
        mem_rd    = (state_q == ST_READ);
        mem_wr    = (state_q == ST_WRITE);
        mem_addr  = addr_q;
        mem_wdata = result_q;
        result    = result_q;
        flags_out = flags_q;
        reg_sel   = code_q;
        cycles    = cycles_q;
    end
endmodule

// File: rtl/rotl_exec_chk.sv
module rotl_exec_chk
    import rotl_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              reg_we,
    input logic [2:0]        reg_sel,
    input logic [7:0]        flags_out,
    input logic [3:0]        cycles,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [7:0]        mem_wdata
);
    // R7
    wr_follows_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> ($past(mem_rd, 2) && (mem_addr == $past(mem_addr, 2))));

    // R7
    rd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> (!mem_rd && !mem_wr && !done));

    // R7
    wr_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> (done && !reg_we));

    // R6
    we_reg_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> (done && !mem_rd && !mem_wr));

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    inflight_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> ($stable(cycles) && $stable(reg_sel)));

    // R3
    hn_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!flags_out[FLG_H] && !flags_out[FLG_N]));

    // R3
    mem_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> ((flags_out[FLG_Z] == (mem_wdata == 8'h00)) &&
                    (flags_out[FLG_S] == mem_wdata[7])));

    // R9
    cycles_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((cycles >= 4'd1) && (cycles <= 4'd8)));

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!done && !mem_rd && !mem_wr && !reg_we));
endmodule

bind rotl_exec_unit rotl_exec_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done      (done),
    .reg_we    (reg_we),
    .reg_sel   (reg_sel),
    .flags_out (flags_out),
    .cycles    (cycles),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata)
);

// File: tb/rotl_exec_unit_test.sv
module rotl_exec_unit_test;
    localparam int AW = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          op_valid = 1'b0;
    logic          page_form = 1'b0;
    logic [7:0]    opcode = 8'h00;
    logic          idx_sel = 1'b0;
    logic          ovr_prefix = 1'b0;
    logic [7:0]    reg_val = 8'h00;
    logic [7:0]    flags_in = 8'h00;
    logic [AW-1:0] ptr_addr = '0;
    logic [AW-1:0] idx_base = '0;
    logic [7:0]    disp = 8'h00;
    logic [7:0]    mem_rdata;
    logic          busy, done, reg_we, mem_rd, mem_wr;
    logic [2:0]    reg_sel;
    logic [7:0]    result, flags_out, mem_wdata;
    logic [3:0]    cycles;
    logic [AW-1:0] mem_addr;

    logic [7:0]    mem [0:255];
    int            n_cmp = 0;
    int            n_bad = 0;
    bit            finished = 0;

    always #4 clk = ~clk;

    rotl_exec_unit #(.ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .page_form(page_form),
        .opcode(opcode), .idx_sel(idx_sel), .ovr_prefix(ovr_prefix),
        .reg_val(reg_val), .flags_in(flags_in), .ptr_addr(ptr_addr),
        .idx_base(idx_base), .disp(disp), .mem_rdata(mem_rdata),
        .busy(busy), .done(done), .reg_we(reg_we), .reg_sel(reg_sel),
        .result(result), .flags_out(flags_out), .cycles(cycles),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata)
    );

    // bench memory: synchronous read, write on strobe
    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];
        if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit even_par(input logic [7:0] v);
        int ones = 0;
        for (int i = 0; i < 8; i++) ones += v[i];
        return (ones % 2) == 0;
    endfunction

    // one operation with full expectation computed from the requirements
    task automatic run_op(input bit pg, input logic [7:0] opc, input bit ix,
                          input bit pre, input logic [7:0] rv, input logic [7:0] fl,
                          input logic [AW-1:0] ptr, input logic [AW-1:0] base,
                          input logic [7:0] d, input bit intrude);
        logic [2:0]    code   = pg ? opc[2:0] : 3'd7;
        bit            thru_c = pg ? opc[4] : 1'b1;
        bit            is_mem = pg && (code == 3'd6);
        bit            is_idx = is_mem && ix;
        logic [AW-1:0] ea     = is_idx ? base + {{(AW-8){d[7]}}, d} : ptr;
        logic [7:0]    opnd   = is_mem ? mem[ea[7:0]] : rv;
        logic [7:0]    eres;
        logic [7:0]    efl;
        logic [3:0]    ecyc;
        int            lat    = is_mem ? 3 : 1;
        int            n      = 0;

        eres = {opnd[6:0], thru_c ? fl[0] : opnd[7]};
        efl  = fl;
        efl[4] = 1'b0; efl[1] = 1'b0; efl[0] = opnd[7];
        if (pg) begin
            efl[7] = eres[7];
            efl[6] = (eres == 8'h00);
            efl[2] = even_par(eres);
        end
        if (!pg)          ecyc = 4'd1;
        else if (!is_mem) ecyc = 4'd2 + {3'b0, pre};
        else if (is_idx)  ecyc = 4'd7 + {3'b0, pre};
        else              ecyc = 4'd5 + {3'b0, pre};

        page_form = pg; opcode = opc; idx_sel = ix; ovr_prefix = pre;
        reg_val = rv; flags_in = fl; ptr_addr = ptr; idx_base = base; disp = d;
        op_valid = 1'b1;
        @(negedge clk);
        op_valid = 1'b0;
        n = 1;
        while (!done && n < 10) begin
            if (is_mem && n == 1) begin
                // R7 read strobe one cycle after acceptance; R8 address
                check(mem_rd === 1'b1, "R7 read strobe", mem_rd, 1);
                check(mem_addr === ea, "R8 read address", mem_addr, ea);
                if (intrude) begin
                    page_form = 1'b1; opcode = 8'h10; reg_val = ~opnd;
                    flags_in = ~fl; op_valid = 1'b1;
                end
            end
            @(negedge clk);
            op_valid = 1'b0;
            n++;
        end
        check(n == lat, is_mem ? "R7 latency" : "R6 latency", n, lat);
        check(result === eres, thru_c ? "R1 result" : "R2 result", result, eres);
        check(flags_out === efl, pg ? "R3 flags" : "R4 flags", flags_out, efl);
        check(cycles === ecyc, "R9 cycles", cycles, ecyc);
        if (is_mem) begin
            check(mem_wr === 1'b1 && reg_we === 1'b0, "R7 write strobe",
                  {mem_wr, reg_we}, 2'b10);
            check(mem_addr === ea && mem_wdata === eres, "R8 write address/data",
                  {mem_addr, mem_wdata}, {ea, eres});
        end else begin
            check(reg_we === 1'b1 && mem_wr === 1'b0 && mem_rd === 1'b0,
                  "R6 register strobe", {reg_we, mem_wr, mem_rd}, 3'b100);
            check(reg_sel === code, pg ? "R5 register select" : "R4 accumulator select",
                  reg_sel, code);
        end
        @(negedge clk);
        if (is_mem)
            check(mem[ea[7:0]] === eres, "R7 memory updated", mem[ea[7:0]], eres);
        if (intrude)
            check(busy === 1'b0 && done === 1'b0, "R10 intruding request ignored",
                  {busy, done}, 2'b00);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'((i * 37) + 5);
        repeat (3) @(negedge clk);
        // R11 reset state
        check({busy, done, reg_we, mem_rd, mem_wr} === 5'b0, "R11 reset outputs",
              {busy, done, reg_we, mem_rd, mem_wr}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check({busy, done, reg_we, mem_rd, mem_wr} === 5'b0, "R11 idle after reset",
              {busy, done, reg_we, mem_rd, mem_wr}, 0);

        // R4 accumulator form, every value, both carries; opcode and prefix ignored
        for (int v = 0; v < 256; v++)
            for (int c = 0; c < 2; c++)
                run_op(1'b0, 8'(v), v[0], v[1], 8'(v),
                       {8'(v)>>1 ^ 8'h35} & 8'hFE | 8'(c), '0, '0, 8'h00, 1'b0);

        // R1 R2 R5 R6 R9: every register code and value, both rotations
        for (int o = 0; o < 2; o++)
            for (int code = 0; code < 8; code++) begin
                if (code == 6) continue;
                for (int v = 0; v < 256; v++)
                    for (int c = 0; c < 2; c++)
                        run_op(1'b1, {3'(v >> 5), 1'(o), 1'(v), 3'(code)}, v[1], v[0],
                               8'(v), (8'(v) ^ 8'hC6) & 8'hFE | 8'(c),
                               '0, '0, 8'(v), 1'b0);
            end

        // R7 R8 pointer-addressed memory
        for (int o = 0; o < 2; o++)
            for (int v = 0; v < 256; v++)
                for (int c = 0; c < 2; c++) begin
                    logic [AW-1:0] p = 24'h3C_0000 | AW'((v * 7) & 8'hFF);
                    mem[p[7:0]] = 8'(v);
                    run_op(1'b1, {3'b000, 1'(o), 4'h6}, 1'b0, c[0], 8'h00,
                           8'(v * 11) & 8'hFE | 8'(c), p, 24'hFFFFFF, 8'h80, 1'b0);
                end

        // R8 indexed memory: every displacement, low and high base (wraps)
        for (int o = 0; o < 2; o++)
            for (int b = 0; b < 2; b++)
                for (int d = 0; d < 256; d++)
                    run_op(1'b1, {3'b000, 1'(o), 4'h6}, 1'b1, d[0], 8'h00,
                           8'(d) ^ 8'h5B, 24'h00_0000,
                           b ? 24'hFF_FFF0 : 24'h00_0010, 8'(d), 1'b0);

        // R10 requests during a memory operation are ignored
        for (int k = 0; k < 8; k++)
            run_op(1'b1, 8'h16, k[0], 1'b0, 8'h00, 8'(k * 29), 24'(k * 3),
                   24'h00_0040, 8'(k * 50), 1'b1);

        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!finished) begin
            finished = 1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule